// File: doc/BRIEF.md
# Eight-bit PWM timer with one compare channel

This block is an 8-bit timer/counter with one output-compare channel. It drives a single waveform output and an output-enable indication. Software sets it up through a small register port: a control register, the counter itself, a compare register and a flag register. The control register picks one of four counting modes, the action taken on the output at a compare event, and a clock divider.

The timer has a free-running mode and a clear-on-compare mode for timing and frequency generation. It also has two PWM modes: single-slope fast PWM and dual-slope phase-correct PWM. In the PWM modes the compare value is double-buffered, so that a duty-cycle change lands at a period boundary. An overflow flag and a compare-match flag stay latched until they are cleared by a write of one.

A force-compare strobe applies the compare action to the output at once. It has no effect on the flags or the counter.

Top module: `pwm8_timer`

## Requirements
- R1: After synchronous reset, every readable register reads 0, both flags are 0, and both `wave_out` and `wave_oe` are 0.
- R2: Clock select (control bits 2:0) value 000 stops the counter. The values 001 to 111 advance it once every 1, 8, 32, 64, 128, 256 or 1024 clocks. The divider restarts on every control write, so the first advance comes exactly N clocks after that write.
- R3: In free-running mode (control bit 3 = 0, bit 6 = 0) the counter counts 0x00 to 0xFF and wraps. The overflow flag is set on the advance that leaves 0xFF.
- R4: In clear-on-compare mode (bit 3 = 1, bit 6 = 0) the advance taken while the counter equals the active compare value returns it to 0. The overflow flag is set only if the counter passes 0xFF.
- R5: The compare flag (flag register bit 1) is set on the advance at which the counter equals the active compare value. Writing 1 to bit 0 (overflow) or bit 1 (compare) of the flag register (address 3) clears that flag, and a bit written as 0 leaves its flag unchanged.
- R6: A compare write is active at once in the two non-PWM modes. In fast PWM (bits 3 and 6 = 1) and phase-correct PWM (bit 3 = 0, bit 6 = 1) it is held and becomes active on the advance taken at counter 0xFF. Reading address 2 returns the last value written.
- R7: In the non-PWM modes, output mode (control bits 5:4) 01 toggles the output on a compare event, 10 clears it and 11 sets it. Output mode 00 leaves it unchanged.
- R8: In fast PWM, output mode 10 clears the output on a match and sets it on the wrap from 0xFF to 0. Output mode 11 does the inverse. When a match and a wrap happen on the same advance, the wrap action wins.
- R9: In phase-correct PWM the counter goes 0 up to 0xFF and then down to 0, with no end value repeated. The overflow flag is set on the advance that leaves 0 while counting down. Output mode 10 clears the output on a match while counting up and sets it on a match while counting down. Output mode 11 does the inverse.
- R10: Writing control bit 7 as 1 together with a non-PWM mode (written bit 6 = 0) applies the written output mode's action to the output at once. It sets no flag and does not move the counter. With bit 6 = 1 it does nothing. Bit 7 always reads 0.
- R11: `wave_oe` is 1 exactly when the output mode is nonzero and `dir_en` is 1.
- R12: Register map: address 0 control (layout as above), address 1 counter (read/write), address 2 compare, address 3 flags. A counter write takes priority over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| dir_en | input | 1 | External pin-direction bit that gates the output enable |
| wave_out | output | 1 | Registered waveform output |
| wave_oe | output | 1 | Waveform output takes the pin |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |

## Verification
Some properties are checked on every cycle:
- a stopped counter holds its value;
- clear-on-compare returns the counter to 0;
- phase-correct mode turns at 0xFF to 0xFE;
- each rising flag edge comes from a legal counter value;
- a force strobe never raises the compare flag and never moves the output in a PWM mode.

Other behaviour only shows over a whole scenario: the exact divider periods, when a buffered compare value takes over, the output edges in each PWM mode, and the position of the overflow flag in each mode. The bench's scripted runs cover these at cycle-exact sample points.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam int DW = 8;
  localparam int PRE_W = 10;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_PHASE  = 2'b01,
    MODE_CTC    = 2'b10,
    MODE_FAST   = 2'b11
  } wgm_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_FLAG = 2'd3;

  function automatic logic is_pwm(input wgm_e m);
    return m[0];
  endfunction
endpackage

// File: rtl/pwm8_prescale.sv
module pwm8_prescale #(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [2:0] csel,
  output logic       tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;
  int unsigned      sh;

  always_comb begin
    case (csel)
      3'd1:    sh = 0;
      3'd2:    sh = 3;
      3'd3:    sh = 5;
      3'd4:    sh = 6;
      3'd5:    sh = 7;
      3'd6:    sh = 8;
      default: sh = 10;
    endcase
    mask = PRE_W'((1 << sh) - 1);
  end

  assign tick = (csel != 3'd0) && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart || csel == 3'd0) pre_q <= '0;
    else                                pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pwm8_counter.sv
module pwm8_counter
  import pwm8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  wgm_e         mode,
  input  logic [W-1:0] ocr_act,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  output logic [W-1:0] cnt,
  output logic         dir_down,
  output logic         at_max,
  output logic         match,
  output logic         ovf_set
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] MAXM1 = MAXV - 1'b1;

  assign at_max  = tick && (cnt == MAXV);
  assign match   = tick && (cnt == ocr_act);
  assign ovf_set = (mode == MODE_PHASE) ? (tick && dir_down && cnt == '0) : at_max;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      dir_down <= 1'b0;
    end else begin
      if (mode != MODE_PHASE) dir_down <= 1'b0;
      if (cnt_wr) begin
        cnt <= cnt_wdata;
      end else if (tick) begin
        case (mode)
          MODE_PHASE: begin
            if (!dir_down) begin
              if (cnt == MAXV) begin
                dir_down <= 1'b1;
                cnt      <= MAXM1;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end else begin
              if (cnt == '0) begin
                dir_down <= 1'b0;
                cnt      <= W'(1);
              end else begin
                cnt <= cnt - 1'b1;
              end
            end
          end
          MODE_CTC: cnt <= (cnt == ocr_act) ? '0 : cnt + 1'b1;
          default:  cnt <= cnt + 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm8_wave.sv
module pwm8_wave
  import pwm8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  wgm_e       mode,
  input  logic [1:0] com,
  input  logic       match,
  input  logic       wrap,
  input  logic       dir_down,
  input  logic       force_evt,
  input  logic [1:0] force_com,
  output logic       wave
);
  function automatic logic plain_act(input logic [1:0] c, input logic cur);
    case (c)
      2'b01:   return !cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  logic nxt;

  always_comb begin
    nxt = wave;
    if (force_evt) begin
      nxt = plain_act(force_com, wave);
    end else begin
      case (mode)
        MODE_FAST: begin
          if (com[1]) begin
            if (wrap)       nxt = !com[0];
            else if (match) nxt = com[0];
          end
        end
        MODE_PHASE: begin
          if (com[1] && match) nxt = dir_down ? !com[0] : com[0];
        end
        default: begin
          if (match) nxt = plain_act(com, wave);
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wave <= 1'b0;
    else     wave <= nxt;
  end
endmodule

// File: rtl/pwm8_timer.sv
module pwm8_timer
  import pwm8_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       dir_en,
  output logic       wave_out,
  output logic       wave_oe,
  output logic       ovf_flag,
  output logic       cmp_flag
);
  wgm_e          mode_q;
  logic [1:0]    com_q;
  logic [2:0]    cs_q;
  logic [DW-1:0] ocr_buf, ocr_act;
  logic [DW-1:0] cnt_q;
  logic          tick, dir_down, at_max, match, ovf_set;
  logic          ctrl_wr, cnt_wr, cmp_wr, flag_wr, force_evt;

  assign ctrl_wr   = wr_en && addr == A_CTRL;
  assign cnt_wr    = wr_en && addr == A_CNT;
  assign cmp_wr    = wr_en && addr == A_CMP;
  assign flag_wr   = wr_en && addr == A_FLAG;
  assign force_evt = ctrl_wr && wdata[7] && !wdata[6];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_NORMAL;
      com_q  <= 2'b00;
      cs_q   <= 3'b000;
    end else if (ctrl_wr) begin
      mode_q <= wgm_e'({wdata[3], wdata[6]});
      com_q  <= wdata[5:4];
      cs_q   <= wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ocr_buf <= '0;
      ocr_act <= '0;
    end else begin
      if (cmp_wr) ocr_buf <= wdata;
      if (!is_pwm(mode_q))  ocr_act <= cmp_wr ? wdata : ocr_buf;
      else if (at_max)      ocr_act <= ocr_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_flag <= 1'b0;
      cmp_flag <= 1'b0;
    end else begin
      if (ovf_set)                    ovf_flag <= 1'b1;
      else if (flag_wr && wdata[0])   ovf_flag <= 1'b0;
      if (match)                      cmp_flag <= 1'b1;
      else if (flag_wr && wdata[1])   cmp_flag <= 1'b0;
    end
  end

  pwm8_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .restart(ctrl_wr), .csel(cs_q), .tick(tick)
  );

  pwm8_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode_q), .ocr_act(ocr_act),
    .cnt_wr(cnt_wr), .cnt_wdata(wdata), .cnt(cnt_q), .dir_down(dir_down),
    .at_max(at_max), .match(match), .ovf_set(ovf_set)
  );

  pwm8_wave u_wave (
    .clk(clk), .rst(rst), .mode(mode_q), .com(com_q), .match(match),
    .wrap(at_max && mode_q == MODE_FAST), .dir_down(dir_down),
    .force_evt(force_evt), .force_com(wdata[5:4]), .wave(wave_out)
  );

  assign wave_oe = dir_en && (com_q != 2'b00);

  always_comb begin
    case (addr)
      A_CTRL:  rdata = {1'b0, mode_q[0], com_q, mode_q[1], cs_q};
      A_CNT:   rdata = cnt_q;
      A_CMP:   rdata = ocr_buf;
      default: rdata = {6'b0, cmp_flag, ovf_flag};
    endcase
  end
endmodule

// File: rtl/pwm8_timer_chk.sv
module pwm8_timer_chk
  import pwm8_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       dir_en,
  input logic [2:0] cs,
  input logic [1:0] mode,
  input logic [7:0] cnt,
  input logic [7:0] ocr_act,
  input logic       tick,
  input logic       dir_down,
  input logic       wave_out,
  input logic       wave_oe,
  input logic       ovf_flag,
  input logic       cmp_flag
);
  logic cnt_w;
  assign cnt_w = wr_en && addr == A_CNT;

  assert_stopped_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (cs == 3'd0 && !cnt_w) |=> $stable(cnt));

  assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(tick) &&
      ($past(cnt) == 8'hFF || ($past(mode) == 2'b01 && $past(cnt) == 8'h00))));

  assert_ctc_wraps_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && tick && cnt == ocr_act && !cnt_w) |=> (cnt == 8'h00));

  assert_cmp_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_flag) |-> ($past(tick) && $past(cnt) == $past(ocr_act)));

  assert_phase_turn_R9: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && tick && !dir_down && cnt == 8'hFF && !cnt_w) |=> (cnt == 8'hFE));

  assert_pwm_force_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTRL && wdata[7] && wdata[6] && !tick) |=> $stable(wave_out));

  assert_force_no_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTRL && wdata[7] && !tick) |=> !$rose(cmp_flag));

  assert_oe_gated_R11: assert property (@(posedge clk) disable iff (rst)
    wave_oe |-> dir_en);
endmodule

bind pwm8_timer pwm8_timer_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .dir_en(dir_en), .cs(cs_q), .mode(mode_q), .cnt(cnt_q), .ocr_act(ocr_act),
  .tick(tick), .dir_down(dir_down), .wave_out(wave_out), .wave_oe(wave_oe),
  .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
);

// File: tb/tb_pwm8_timer.sv
module tb_pwm8_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       dir_en = 1'b1;
  logic       wave_out, wave_oe, ovf_flag, cmp_flag;

  always #2 clk = ~clk;

  pwm8_timer dut (.*);

  typedef struct { string req; logic [15:0] act; logic [15:0] exp; } item_t;
  item_t sb[$];
  int nvec = 0, nfail = 0, pos = 0;
  bit done = 0;

  // monitor: pops scoreboard items and compares
  initial forever begin
    item_t it;
    wait (sb.size() != 0);
    it = sb.pop_front();
    nvec++;
    if (it.act !== it.exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", it.req, it.act, it.exp);
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    item_t it;
    it.req = req; it.act = act; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start(input logic [7:0] d);
    wr(2'd0, d);
    pos = 0;
  endtask

  task automatic run_to(input int k);
    repeat (k - pos) @(negedge clk);
    pos = k;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #0.5;
    chk(req, {8'h00, rdata}, {8'h00, exp});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  logic w0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_reg("R1 ctrl", 2'd0, 8'h00);
    chk_reg("R1 cnt", 2'd1, 8'h00);
    chk_reg("R1 cmp", 2'd2, 8'h00);
    chk_reg("R1 flags", 2'd3, 8'h00);
    chk("R1 wave", {15'b0, wave_out}, 16'h0);
    chk("R1 oe", {15'b0, wave_oe}, 16'h0);

    // R10/R7 force toggle, reads zero, no flag; R11 oe
    wr(2'd0, 8'h90);
    chk_reg("R10 force bit reads 0", 2'd0, 8'h10);
    chk("R10 force toggles", {15'b0, wave_out}, 16'h1);
    chk_reg("R10 force sets no flag", 2'd3, 8'h00);
    chk("R11 oe on", {15'b0, wave_oe}, 16'h1);
    dir_en = 1'b0; #0.5;
    chk("R11 oe gated by dir_en", {15'b0, wave_oe}, 16'h0);
    dir_en = 1'b1;
    wr(2'd0, 8'h90);
    chk("R7 toggle back", {15'b0, wave_out}, 16'h0);
    wr(2'd0, 8'h00);
    chk("R11 oe off when disconnected", {15'b0, wave_oe}, 16'h0);

    // R2 stopped
    wr(2'd1, 8'h40);
    repeat (20) @(negedge clk);
    chk_reg("R2 stopped holds / R12 cnt read", 2'd1, 8'h40);

    // R3 normal overflow, R5 compare flag at 0
    wr(2'd3, 8'h03);
    wr(2'd1, 8'hF0);
    start(8'h01);
    run_to(15);
    chk_reg("R3 cnt at FF", 2'd1, 8'hFF);
    chk("R3 no ovf yet", {15'b0, ovf_flag}, 16'h0);
    run_to(16);
    chk_reg("R3 wrap", 2'd1, 8'h00);
    chk("R3 ovf set", {15'b0, ovf_flag}, 16'h1);
    chk("R5 no cmp yet", {15'b0, cmp_flag}, 16'h0);
    run_to(17);
    chk("R5 cmp set", {15'b0, cmp_flag}, 16'h1);
    wr(2'd0, 8'h00);
    // R5 write-one-to-clear
    wr(2'd3, 8'h01);
    chk_reg("R5 clear ovf only", 2'd3, 8'h02);
    wr(2'd3, 8'h02);
    chk_reg("R5 clear cmp", 2'd3, 8'h00);

    // R2 divide by 8 and 1024
    wr(2'd1, 8'h00);
    start(8'h02);
    run_to(7);
    chk_reg("R2 div8 before", 2'd1, 8'h00);
    run_to(8);
    chk_reg("R2 div8 first", 2'd1, 8'h01);
    run_to(64);
    chk_reg("R2 div8 eight", 2'd1, 8'h08);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    start(8'h07);
    run_to(1023);
    chk_reg("R2 div1024 before", 2'd1, 8'h00);
    run_to(1024);
    chk_reg("R2 div1024 first", 2'd1, 8'h01);
    wr(2'd0, 8'h00);

    // R4 CTC, R7 toggle on match
    wr(2'd0, 8'hA0);
    wr(2'd3, 8'h03);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h05);
    chk_reg("R12 cmp read", 2'd2, 8'h05);
    start(8'h19);
    run_to(5);
    chk_reg("R4 cnt reaches top", 2'd1, 8'h05);
    chk("R7 wave before match", {15'b0, wave_out}, 16'h0);
    run_to(6);
    chk_reg("R4 cleared at top", 2'd1, 8'h00);
    chk("R7 toggled", {15'b0, wave_out}, 16'h1);
    chk("R5 cmp flag ctc", {15'b0, cmp_flag}, 16'h1);
    run_to(12);
    chk("R7 toggled again", {15'b0, wave_out}, 16'h0);
    run_to(40);
    chk("R4 no ovf below FF", {15'b0, ovf_flag}, 16'h0);
    wr(2'd0, 8'h18);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h02);
    start(8'h19);
    run_to(2);
    chk_reg("R6 immediate ctc top", 2'd1, 8'h02);
    run_to(3);
    chk_reg("R6 immediate ctc wrap", 2'd1, 8'h00);
    wr(2'd0, 8'h18);
    wr(2'd1, 8'h03);
    wr(2'd3, 8'h03);
    w0 = wave_out;
    wr(2'd0, 8'h98);
    chk_reg("R10 force keeps counter", 2'd1, 8'h03);
    chk("R10 force toggles in ctc", {15'b0, wave_out}, {15'b0, ~w0});
    chk_reg("R10 force no flag ctc", 2'd3, 8'h00);

    // R6/R8 fast PWM
    wr(2'd0, 8'h00);
    wr(2'd0, 8'hB0);
    wr(2'd2, 8'h10);
    wr(2'd0, 8'h68);
    wr(2'd2, 8'h20);
    chk_reg("R6 reads buffered value", 2'd2, 8'h20);
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h03);
    start(8'h69);
    run_to(16);
    chk("R8 high before match", {15'b0, wave_out}, 16'h1);
    run_to(17);
    chk("R6 old compare still active", {15'b0, wave_out}, 16'h0);
    chk("R5 cmp fast", {15'b0, cmp_flag}, 16'h1);
    run_to(256);
    chk_reg("R8 wrapped", 2'd1, 8'h00);
    chk("R8 set at bottom", {15'b0, wave_out}, 16'h1);
    chk("R3 ovf fast", {15'b0, ovf_flag}, 16'h1);
    run_to(288);
    chk("R6 new value not hit yet", {15'b0, wave_out}, 16'h1);
    run_to(289);
    chk("R6 new compare active", {15'b0, wave_out}, 16'h0);
    wr(2'd0, 8'h68);
    wr(2'd0, 8'hF8);
    chk("R10 force ignored in PWM", {15'b0, wave_out}, 16'h0);

    // R9 phase-correct
    wr(2'd0, 8'h00);
    wr(2'd0, 8'hB0);
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h60);
    wr(2'd2, 8'h80);
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h03);
    start(8'h61);
    run_to(2);
    chk("R9 high before up match", {15'b0, wave_out}, 16'h1);
    run_to(3);
    chk("R9 cleared on up match", {15'b0, wave_out}, 16'h0);
    run_to(255);
    chk_reg("R9 top", 2'd1, 8'hFF);
    run_to(256);
    chk_reg("R9 turn no repeat", 2'd1, 8'hFE);
    chk("R9 no ovf at top", {15'b0, ovf_flag}, 16'h0);
    run_to(382);
    chk_reg("R9 down at 80", 2'd1, 8'h80);
    chk("R9 still low", {15'b0, wave_out}, 16'h0);
    run_to(383);
    chk("R9 set on down match (R6 loaded at top)", {15'b0, wave_out}, 16'h1);
    run_to(510);
    chk_reg("R9 bottom", 2'd1, 8'h00);
    chk("R9 no ovf yet", {15'b0, ovf_flag}, 16'h0);
    run_to(511);
    chk_reg("R9 turn at bottom", 2'd1, 8'h01);
    chk("R9 ovf at bottom", {15'b0, ovf_flag}, 16'h1);
    wr(2'd0, 8'h00);

    wait (sb.size() == 0);
    #1;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule